// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a successive-approximation analog-to-digital converter that sits behind a small memory-mapped register port. Software picks one of eight inputs and sets the power bit in the control register. The controller then waits a programmed number of clocks so the analog front end can settle. After that it runs a ten-step binary search. On each step it drives a trial code to an external DAC and comparator pair and reads back one comparator bit.

When the search ends, the code is latched into the result register and the interrupt status flag is set. An interrupt line rises when interrupts are enabled. Writing zero to the control register acknowledges the interrupt and powers the front end down. The same write aborts any conversion that is still running.

Top module: `sar_conv_top`

## Requirements
- R1: After reset the result register reads 0, status reads 0, control reads 0, the delay register reads 8, and irq, powerOn and chanSel are all low.
- R2: Reads are combinational on addr. Offset 0x0 gives the result in bits [9:0]. Offset 0x4 gives busy in bit 0. Offset 0x8 gives channel [2:0], power bit 3, interrupt enable bit 5 and interrupt status bit 6. Offset 0xC gives the 6-bit delay in bits [5:0]. All other bits read 0.
- R3: A write to the control register with bit 3 set starts a conversion. Busy reads 1 from the cycle after the write for exactly D+10 cycles, where D is the delay register value.
- R4: The search runs MSB first, one bit per clock. Each step drives trialCode as the bits kept so far plus the bit under test. The bit is kept only when cmpHigh is 1, meaning the input is at or above the trial level. The final code therefore equals the input level.
- R5: A delay of 0 starts the approximation on the next clock: right after the starting write, trialCode is 0x200.
- R6: When a conversion completes, interrupt status (control bit 6) is set and stays set until cleared. irq is high exactly when both status and enable are set.
- R7: Any write to the control register clears interrupt status. A write with bit 3 clear powers down and aborts a running conversion: busy drops after that write, status is not set, and the result keeps its old value.
- R8: A control write with bit 3 set while busy restarts the sequence from the delay phase, and completion is timed from that second write.
- R9: The result register holds the last completed code until the next conversion finishes.
- R10: powerOn follows control bit 3. chanSel follows control bits [2:0] while power is on and is 0 while power is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter and register clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr |
| cmpHigh | input | 1 | Comparator: input is at or above the trial level |
| trialCode | output | 10 | Trial code to the DAC |
| chanSel | output | 3 | Input multiplexer select |
| powerOn | output | 1 | Analog front-end power enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are a control write that lands in the middle of a running search, either an abort or a restart. In those cases the old result must survive and the completion time must move. The bench counts clocks from the starting write and issues a second control write inside the settle or approximation window. It then checks busy and the result register on the exact cycles before and after the new completion point. The comparator is modelled in the bench as an ideal compare of a chosen level against trialCode, so each expected code is simply that level, including 0 and 1023.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFFS_RESULT = 4'h0;
  localparam logic [ADDR_W-1:0] OFFS_STATUS = 4'h4;
  localparam logic [ADDR_W-1:0] OFFS_CTRL   = 4'h8;
  localparam logic [ADDR_W-1:0] OFFS_DELAY  = 4'hC;

  localparam int CHAN_LSB = 0;
  localparam int PWR_BIT  = 3;
  localparam int IEN_BIT  = 5;
  localparam int ISTS_BIT = 6;
  localparam int BUSY_BIT = 0;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2
  } sarState_t;

  typedef struct packed {
    logic start;
    logic step;
    logic latch;
  } sarStrobe_t;
endpackage

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int CHAN_BITS = 3,
  parameter int DLY_BITS  = 6,
  parameter int DLY_RESET = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output sarStrobe_t           strb,
  output logic                 busy,
  output logic [CHAN_BITS-1:0] chanQ,
  output logic                 pwrQ,
  output logic                 ienQ,
  output logic                 istsQ,
  output logic [DLY_BITS-1:0]  delayQ
);
  localparam int STEP_W = $clog2(RES_BITS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RES_BITS - 1);

  sarState_t            state;
  logic [DLY_BITS-1:0]  settleCnt;
  logic [STEP_W-1:0]    stepCnt;
  logic                 wrCtrl, wrDly, startReq, settleEnd;

  assign wrCtrl    = wrEn && (addr == OFFS_CTRL);
  assign wrDly     = wrEn && (addr == OFFS_DELAY);
  assign startReq  = wrCtrl && wrData[PWR_BIT];
  assign settleEnd = (state == ST_SETTLE) && (settleCnt == DLY_BITS'(1));
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strb       = '0;
    strb.start = (startReq && (delayQ == '0)) || (settleEnd && !wrCtrl);
    strb.step  = (state == ST_CONV) && !wrCtrl;
    strb.latch = strb.step && (stepCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanQ     <= '0;
      pwrQ      <= 1'b0;
      ienQ      <= 1'b0;
      istsQ     <= 1'b0;
      delayQ    <= DLY_BITS'(DLY_RESET);
      state     <= ST_IDLE;
      settleCnt <= '0;
      stepCnt   <= '0;
    end else begin
      if (wrDly) delayQ <= wrData[DLY_BITS-1:0];
      if (wrCtrl) begin
        chanQ <= wrData[CHAN_LSB +: CHAN_BITS];
        pwrQ  <= wrData[PWR_BIT];
        ienQ  <= wrData[IEN_BIT];
        istsQ <= 1'b0;
        if (wrData[PWR_BIT]) begin
          if (delayQ == '0) begin
            state   <= ST_CONV;
            stepCnt <= LAST_STEP;
          end else begin
            state     <= ST_SETTLE;
            settleCnt <= delayQ;
          end
        end else begin
          state <= ST_IDLE;
        end
      end else begin
        case (state)
          ST_SETTLE: begin
            if (settleEnd) begin
              state   <= ST_CONV;
              stepCnt <= LAST_STEP;
            end else begin
              settleCnt <= settleCnt - DLY_BITS'(1);
            end
          end
          ST_CONV: begin
            if (stepCnt == '0) begin
              state <= ST_IDLE;
              istsQ <= 1'b1;
            end else begin
              stepCnt <= stepCnt - STEP_W'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: a start write makes the block busy on the next cycle
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (state != ST_IDLE));

  // R5: zero delay goes straight to approximation
  p_zero_delay_r5: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && (delayQ == '0)) |=> (state == ST_CONV));

  // R6: the last step sets interrupt status and ends the conversion
  p_done_status_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_CONV) && (stepCnt == '0) && !wrCtrl) |=> (istsQ && state == ST_IDLE));

  // R7: a power-down write aborts and leaves status clear
  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !wrData[PWR_BIT]) |=> (state == ST_IDLE && !istsQ));
endmodule

// File: rtl/sar_conv_dp.sv
module sar_conv_dp
  import sar_conv_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  sarStrobe_t          strb,
  input  logic                cmpHigh,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] resultQ
);
  localparam logic [RES_BITS-1:0] MSB_MASK = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] sarQ, maskQ, resolved;

  assign trialCode = sarQ | maskQ;
  assign resolved  = cmpHigh ? (sarQ | maskQ) : sarQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarQ    <= '0;
      maskQ   <= '0;
      resultQ <= '0;
    end else begin
      if (strb.start) begin
        sarQ  <= '0;
        maskQ <= MSB_MASK;
      end else if (strb.step) begin
        sarQ  <= resolved;
        maskQ <= maskQ >> 1;
      end
      if (strb.latch) resultQ <= resolved;
    end
  end

  // R4: at most one bit under test at any time
  p_mask_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(maskQ));

  // R9: the result only changes on a completing step
  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latch |=> $stable(resultQ));
endmodule

// File: rtl/sar_conv_top.sv
module sar_conv_top
  import sar_conv_pkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int CHAN_BITS = 3,
  parameter int DLY_BITS  = 6,
  parameter int DLY_RESET = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 cmpHigh,
  output logic [RES_BITS-1:0]  trialCode,
  output logic [CHAN_BITS-1:0] chanSel,
  output logic                 powerOn,
  output logic                 irq
);
  sarStrobe_t           strb;
  logic                 busy, pwrQ, ienQ, istsQ;
  logic [CHAN_BITS-1:0] chanQ;
  logic [DLY_BITS-1:0]  delayQ;
  logic [RES_BITS-1:0]  resultQ;

  sar_conv_ctrl #(
    .RES_BITS(RES_BITS), .CHAN_BITS(CHAN_BITS), .DLY_BITS(DLY_BITS),
    .DLY_RESET(DLY_RESET), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .busy(busy), .chanQ(chanQ), .pwrQ(pwrQ), .ienQ(ienQ),
    .istsQ(istsQ), .delayQ(delayQ)
  );

  sar_conv_dp #(.RES_BITS(RES_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .resultQ(resultQ)
  );

  assign powerOn = pwrQ;
  assign chanSel = pwrQ ? chanQ : '0;
  assign irq     = istsQ & ienQ;

  always_comb begin
    rdData = '0;
    case (addr)
      OFFS_RESULT: rdData[RES_BITS-1:0] = resultQ;
      OFFS_STATUS: rdData[BUSY_BIT]     = busy;
      OFFS_CTRL: begin
        rdData[CHAN_LSB +: CHAN_BITS] = chanQ;
        rdData[PWR_BIT]               = pwrQ;
        rdData[IEN_BIT]               = ienQ;
        rdData[ISTS_BIT]              = istsQ;
      end
      OFFS_DELAY:  rdData[DLY_BITS-1:0] = delayQ;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: tb/sar_conv_top_tb.sv
module sar_conv_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {chan[2:0], delay[5:0], level[9:0], ien}
  localparam logic [19:0] VECS [0:NVEC-1] = '{
    {3'd0, 6'd8,  10'd517,  1'b1},
    {3'd1, 6'd3,  10'd0,    1'b1},
    {3'd2, 6'd1,  10'd1023, 1'b0},
    {3'd5, 6'd0,  10'd341,  1'b1},
    {3'd7, 6'd63, 10'd682,  1'b1},
    {3'd3, 6'd2,  10'd1,    1'b0}
  };

  logic        clk = 0, rstN = 0, wrEn = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wrData = 0, rdData;
  logic [9:0]  trialCode, level = 0;
  logic [2:0]  chanSel;
  logic        powerOn, irq, cmpHigh;
  int          checks = 0, errors = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmpHigh = (level >= trialCode);

  sar_conv_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cmpHigh(cmpHigh), .trialCode(trialCode),
    .chanSel(chanSel), .powerOn(powerOn), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    waitCyc(3);
    rstN = 1;
    waitCyc(1);

    // R1 reset state
    readReg(4'h0, v); check(v == 0, "R1 result", v, 0);
    readReg(4'h4, v); check(v == 0, "R1 status", v, 0);
    readReg(4'h8, v); check(v == 0, "R1 control", v, 0);
    readReg(4'hC, v); check(v == 8, "R1 delay", v, 8);
    check({irq, powerOn, chanSel} == 0, "R1 outputs", {irq, powerOn, chanSel}, 0);

    // Vector table: R3 R4 R6 R10
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] ch; logic [5:0] dly; logic [9:0] lv; logic ie;
      {ch, dly, lv, ie} = VECS[i];
      level = lv;
      writeReg(4'hC, {26'd0, dly});
      writeReg(4'h8, {26'd0, ie, 1'b0, 1'b1, ch});
      readReg(4'h4, v); check(v == 1, "R3 busy after start", v, 1);
      check(chanSel == ch && powerOn, "R10 chanSel while powered", {powerOn, chanSel}, {1'b1, ch});
      waitCyc(dly + 9);
      readReg(4'h4, v); check(v == 1, "R3 busy last cycle", v, 1);
      waitCyc(1);
      readReg(4'h4, v); check(v == 0, "R3 busy cleared", v, 0);
      readReg(4'h0, v); check(v == {22'd0, lv}, "R4 result code", v, {22'd0, lv});
      readReg(4'h8, v); check(v[6] == 1'b1, "R6 status set", v, {25'd0, 1'b1, ie, 1'b0, 1'b1, ch});
      check(irq == ie, "R6 irq gating", irq, ie);
      writeReg(4'h8, 0);
      readReg(4'h8, v); check(v == 0, "R7 status cleared", v, 0);
      check({irq, powerOn, chanSel} == 0, "R10 outputs off", {irq, powerOn, chanSel}, 0);
    end

    // R2 upper bits and unused fields
    readReg(4'h0, v); check(v == 32'd1, "R2 result field", v, 1);
    writeReg(4'hC, 32'hFFFF_FFFF);
    readReg(4'hC, v); check(v == 32'h3F, "R2 delay field", v, 32'h3F);
    writeReg(4'h8, 32'hFFFF_FFFF);
    readReg(4'h8, v); check(v == 32'h2F, "R2 control fields", v, 32'h2F);
    writeReg(4'h8, 0);

    // R5 zero delay: first trial on next clock
    level = 10'd900;
    writeReg(4'hC, 0);
    writeReg(4'h8, 32'h8);
    check(trialCode == 10'h200, "R5 first trial", trialCode, 32'h200);
    waitCyc(1);
    check(trialCode == 10'h300, "R4 second trial kept MSB", trialCode, 32'h300);
    waitCyc(9);
    readReg(4'h0, v); check(v == 900, "R5 result", v, 900);
    writeReg(4'h8, 0);

    // R7 abort mid-conversion keeps old result
    level = 10'd300;
    writeReg(4'hC, 4);
    writeReg(4'h8, 32'h28);
    waitCyc(6);
    writeReg(4'h8, 0);
    readReg(4'h4, v); check(v == 0, "R7 busy after abort", v, 0);
    waitCyc(20);
    readReg(4'h0, v); check(v == 900, "R7 result kept", v, 900);
    check(irq == 0, "R7 no irq after abort", irq, 0);

    // R8 restart while busy, R9 hold until completion
    level = 10'd700;
    writeReg(4'hC, 5);
    writeReg(4'h8, 32'h29);
    waitCyc(8);
    writeReg(4'h8, 32'h29);
    waitCyc(14);
    readReg(4'h4, v); check(v == 1, "R8 still busy after restart", v, 1);
    readReg(4'h0, v); check(v == 900, "R9 old result held", v, 900);
    waitCyc(1);
    readReg(4'h4, v); check(v == 0, "R8 done on new timing", v, 0);
    readReg(4'h0, v); check(v == 700, "R8 result", v, 700);
    check(irq == 1, "R6 irq after restart", irq, 1);
    writeReg(4'h8, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule